// File: doc/BRIEF.md
# T1 Receive Data Link Capture

This block collects the data-link bits recovered from an incoming T1 stream and hands them to a host one byte at a time. In extended-superframe operation each data-link slot carries one bit. The block packs eight such bits into a byte, least significant bit first. At one slot every 250 us a byte is complete every 2 ms. In superframe (D4) operation the slot bits are the Fs framing bits. The host copy is then refreshed only at each multiframe boundary, and it holds just the six Fs bits of that multiframe.

Each completed byte moves into a holding register, so a host read stays stable while the next byte is assembled. A latched full flag reports the new byte. When its mask input is set, an active-low interrupt follows the full flag. The host clears the full flag and the overrun flag by writing ones to them. A byte that is not collected within one fill period is overwritten by the next byte, and the overrun flag records the loss. The captured bits are passed on exactly as received, with no zero-bit removal. Frame alignment, HDLC handling and code detection belong to other blocks.

Top module: `t1_rx_datalink_capture`

## Requirements
- R1: While `rstN` is low and after its release, `dataOut` is 0x00, `fullOut` and `overrunOut` are 0, and `irqN` is 1.
- R2: With `modeD4`=0, the eighth `slotStrobe` completes a byte. By the second rising clock edge after that strobe, `dataOut` bit i holds the (i+1)-th bit received, so the first bit lands in bit 0.
- R3: `fullOut` sets in the same cycle that `dataOut` takes a new byte. `irqN` is 0 exactly when `fullOut`=1 and `maskFull`=1, and is 1 otherwise.
- R4: With `modeD4`=1, slot strobes alone never change `dataOut`. A `mfStrobe` loads `dataOut` with the last six bits received: the oldest of them in bit 0, the newest in bit 5, and bits 7:6 as 0.
- R5: The received bits are stored exactly as they arrive, with no zero-bit removal. A run of five or more ones followed by a zero is kept unchanged.
- R6: A new byte that arrives while `fullOut` is still 1 replaces `dataOut` and sets `overrunOut`.
- R7: A cycle with `clrWrEn`=1 clears `fullOut` if `clrBits[0]`=1 and clears `overrunOut` if `clrBits[1]`=1. Zero bits leave their flag unchanged. If a byte transfer happens in the same cycle, `fullOut` ends up set and `overrunOut` does not set.
- R8: With `modeD4`=0, `mfStrobe` has no effect on `dataOut` or `fullOut`.
- R9: A change of `modeD4` discards the partly assembled byte and restarts the bit count.
- R10: `dataOut` changes only as the result of a byte transfer, and it stays stable between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeD4 | input | 1 | 0 = extended-superframe data link, 1 = D4 Fs bits |
| slotStrobe | input | 1 | One-cycle pulse marking a data-link or Fs slot |
| slotBit | input | 1 | Received bit, valid when `slotStrobe` is 1 |
| mfStrobe | input | 1 | One-cycle pulse at a multiframe boundary |
| clrWrEn | input | 1 | Host write strobe for the status flags |
| clrBits | input | 2 | Write-one-to-clear: bit 0 = full, bit 1 = overrun |
| maskFull | input | 1 | 1 lets the full flag drive the interrupt |
| dataOut | output | 8 | Host-visible holding register |
| fullOut | output | 1 | Latched byte-ready flag |
| overrunOut | output | 1 | Latched lost-byte flag |
| irqN | output | 1 | Active-low interrupt |

## Verification
On every cycle the assertions check four things. The holding register changes only two cycles after a slot or multiframe strobe, and the full flag rises only at such a transfer. Overrun rises only while the flag was already full. The interrupt follows the full flag and its mask, and a write-one-to-clear with no transfer due empties the flag. In D4 mode a transfer never fills the upper two bits. Three behaviours need the bench's scenarios, because no single-cycle relation captures them. These are the bit order and content of the captured bytes in both modes, the loss of a partial byte on a mode change, and the priority between a clear and a transfer in the same cycle.

// File: rtl/t1dl_pkg.sv
package t1dl_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic shiftEn;
    logic clearShift;
    logic loadHold;
  } rxdlStrobes_t;

  localparam int STATUS_BITS = 2;
  localparam int FULL_IDX    = 0;
  localparam int OVR_IDX     = 1;

endpackage

// File: rtl/rxdl_ctrl.sv
module rxdl_ctrl
  import t1dl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FS_BITS = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   modeD4,
  input  logic                   slotStrobe,
  input  logic                   mfStrobe,
  input  logic                   clrWrEn,
  input  logic [STATUS_BITS-1:0] clrBits,
  input  logic                   maskFull,
  output rxdlStrobes_t           strobes,
  output logic                   fullOut,
  output logic                   overrunOut,
  output logic                   irqN
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic             modePrev;
  logic             modeChange;
  logic [CNT_W-1:0] bitCnt;
  logic             byteDone;
  logic             loadPend;
  logic             clrFull;
  logic             clrOvr;

  assign modeChange = (modeD4 != modePrev);

  // ESF completes on the last slot of a byte; D4 completes on the boundary
  always_comb begin
    if (modeChange) begin
      byteDone = 1'b0;
    end else if (modeD4) begin
      byteDone = mfStrobe;
    end else begin
      byteDone = slotStrobe && (bitCnt == CNT_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= 1'b0;
      bitCnt   <= '0;
      loadPend <= 1'b0;
    end else begin
      modePrev <= modeD4;
      loadPend <= byteDone;
      if (modeChange || modeD4) begin
        bitCnt <= '0;
      end else if (slotStrobe) begin
        bitCnt <= (bitCnt == CNT_LAST) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.shiftEn    = slotStrobe && !modeChange;
    strobes.clearShift = modeChange;
    strobes.loadHold   = loadPend;
  end

  assign clrFull = clrWrEn && clrBits[FULL_IDX];
  assign clrOvr  = clrWrEn && clrBits[OVR_IDX];

  // A transfer wins over a clear of the same flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullOut    <= 1'b0;
      overrunOut <= 1'b0;
    end else begin
      if (loadPend) begin
        fullOut <= 1'b1;
      end else if (clrFull) begin
        fullOut <= 1'b0;
      end
      if (loadPend && fullOut && !clrFull) begin
        overrunOut <= 1'b1;
      end else if (clrOvr) begin
        overrunOut <= 1'b0;
      end
    end
  end

  assign irqN = !(fullOut && maskFull);

endmodule

// File: rtl/rxdl_datapath.sv
module rxdl_datapath
  import t1dl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FS_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeD4,
  input  logic              slotBit,
  input  rxdlStrobes_t      strobes,
  output logic [DATA_W-1:0] dataOut
);

  localparam int ESF_TOP = DATA_W - 1;
  localparam int D4_TOP  = FS_BITS - 1;

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] holdReg;

  // New bit enters at the top of the active field; older bits move down
  for (genvar i = 0; i < DATA_W; i++) begin : g_shift
    if (i < D4_TOP) begin : g_low
      assign shiftNext[i] = shiftReg[i+1];
    end else if (i == D4_TOP && i < ESF_TOP) begin : g_fsTop
      assign shiftNext[i] = modeD4 ? slotBit : shiftReg[i+1];
    end else if (i < ESF_TOP) begin : g_mid
      assign shiftNext[i] = modeD4 ? 1'b0 : shiftReg[i+1];
    end else if (i == D4_TOP) begin : g_shared
      assign shiftNext[i] = slotBit;
    end else begin : g_top
      assign shiftNext[i] = modeD4 ? 1'b0 : slotBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.clearShift) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.loadHold) begin
      holdReg <= shiftReg;
    end
  end

  assign dataOut = holdReg;

endmodule

// File: rtl/t1_rx_datalink_capture.sv
module t1_rx_datalink_capture
  import t1dl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FS_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeD4,
  input  logic              slotStrobe,
  input  logic              slotBit,
  input  logic              mfStrobe,
  input  logic              clrWrEn,
  input  logic [1:0]        clrBits,
  input  logic              maskFull,
  output logic [DATA_W-1:0] dataOut,
  output logic              fullOut,
  output logic              overrunOut,
  output logic              irqN
);

  rxdlStrobes_t strobes;

  rxdl_ctrl #(
    .DATA_W (DATA_W),
    .FS_BITS(FS_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeD4    (modeD4),
    .slotStrobe(slotStrobe),
    .mfStrobe  (mfStrobe),
    .clrWrEn   (clrWrEn),
    .clrBits   (clrBits),
    .maskFull  (maskFull),
    .strobes   (strobes),
    .fullOut   (fullOut),
    .overrunOut(overrunOut),
    .irqN      (irqN)
  );

  rxdl_datapath #(
    .DATA_W (DATA_W),
    .FS_BITS(FS_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .modeD4 (modeD4),
    .slotBit(slotBit),
    .strobes(strobes),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/rxdl_checker.sv
module rxdl_checker #(
  parameter int DATA_W  = 8,
  parameter int FS_BITS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeD4,
  input logic              slotStrobe,
  input logic              mfStrobe,
  input logic              clrWrEn,
  input logic [1:0]        clrBits,
  input logic              maskFull,
  input logic [DATA_W-1:0] dataOut,
  input logic              fullOut,
  input logic              overrunOut,
  input logic              irqN
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> ($past(slotStrobe, 2) || $past(mfStrobe, 2)));

  // R3
  full_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullOut) |-> ($past(slotStrobe, 2) || $past(mfStrobe, 2)));

  // R6
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunOut) |-> $past(fullOut));

  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!maskFull || !fullOut) |-> irqN);

  // R3
  irq_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskFull && fullOut) |-> !irqN);

  // R4
  d4_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeD4, 2) && $past(modeD4) && !$stable(dataOut))
      |-> (dataOut[DATA_W-1:FS_BITS] == '0));

  // R7
  w1c_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrEn && clrBits[0] && !$past(slotStrobe) && !$past(mfStrobe))
      |=> !fullOut);

endmodule

bind t1_rx_datalink_capture rxdl_checker #(
  .DATA_W (DATA_W),
  .FS_BITS(FS_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeD4    (modeD4),
  .slotStrobe(slotStrobe),
  .mfStrobe  (mfStrobe),
  .clrWrEn   (clrWrEn),
  .clrBits   (clrBits),
  .maskFull  (maskFull),
  .dataOut   (dataOut),
  .fullOut   (fullOut),
  .overrunOut(overrunOut),
  .irqN      (irqN)
);

// File: tb/t1_rx_datalink_capture_tb.sv
`timescale 1ns/1ps
module t1_rx_datalink_capture_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeD4;
  logic       slotStrobe;
  logic       slotBit;
  logic       mfStrobe;
  logic       clrWrEn;
  logic [1:0] clrBits;
  logic       maskFull;
  logic [7:0] dataOut;
  logic       fullOut;
  logic       overrunOut;
  logic       irqN;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  doneFlag = 1'b0;

  always #2 clk = ~clk;

  t1_rx_datalink_capture u_dut (
    .clk(clk), .rstN(rstN), .modeD4(modeD4), .slotStrobe(slotStrobe),
    .slotBit(slotBit), .mfStrobe(mfStrobe), .clrWrEn(clrWrEn),
    .clrBits(clrBits), .maskFull(maskFull), .dataOut(dataOut),
    .fullOut(fullOut), .overrunOut(overrunOut), .irqN(irqN)
  );

  // {d4, bits sent LSB first, expected dataOut}
  localparam int NVEC = 8;
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 8'hA5, 8'hA5},   // R2
    {1'b0, 8'h7E, 8'h7E},   // R5 run of six ones framed by zeros
    {1'b0, 8'h3E, 8'h3E},   // R5 five ones then zero
    {1'b0, 8'h01, 8'h01},   // R2 first bit lands in bit 0
    {1'b1, 8'h1C, 8'h1C},   // R4 Fs pattern
    {1'b1, 8'h2B, 8'h2B},   // R4
    {1'b1, 8'hFF, 8'h3F},   // R4 upper bits stay zero
    {1'b0, 8'hFF, 8'hFF}    // R5
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    slotBit    = b;
    slotStrobe = 1'b1;
    @(negedge clk);
    slotStrobe = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) sendBit(v[i]);
  endtask

  task automatic pulseMf();
    @(negedge clk);
    mfStrobe = 1'b1;
    @(negedge clk);
    mfStrobe = 1'b0;
  endtask

  task automatic clearFlags(input logic [1:0] b);
    @(negedge clk);
    clrWrEn = 1'b1;
    clrBits = b;
    @(negedge clk);
    clrWrEn = 1'b0;
    clrBits = 2'b00;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] prev;
    rstN = 1'b0; modeD4 = 1'b0; slotStrobe = 1'b0; slotBit = 1'b0;
    mfStrobe = 1'b0; clrWrEn = 1'b0; clrBits = 2'b00; maskFull = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 data", dataOut, 8'h00);
    check("R1 full", fullOut, 0);
    check("R1 ovr", overrunOut, 0);
    check("R1 irq", irqN, 1);
    rstN = 1'b1;
    settle();
    check("R1 data after release", dataOut, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      modeD4 = VECS[v][16];
      settle();
      prev = dataOut;
      if (VECS[v][16]) begin
        sendBits(VECS[v][15:8], 6);
        settle();
        check("R4 slots alone hold data", dataOut, prev);
        pulseMf();
      end else begin
        sendBits(VECS[v][15:8], 8);
      end
      settle();
      check(VECS[v][16] ? "R4 D4 byte" : "R2/R5 ESF byte", dataOut, VECS[v][7:0]);
      check("R3 full set", fullOut, 1);
      check("R3 irq low", irqN, 0);
      clearFlags(2'b11);
      check("R7 full cleared", fullOut, 0);
      check("R3 irq released", irqN, 1);
    end

    // R3 masked interrupt
    modeD4 = 1'b0; maskFull = 1'b0;
    settle();
    sendBits(8'h5A, 8);
    settle();
    check("R3 masked full", fullOut, 1);
    check("R3 masked irq", irqN, 1);

    // R6 overwrite while full
    sendBits(8'hC3, 8);
    settle();
    check("R6 overwrite", dataOut, 8'hC3);
    check("R6 overrun", overrunOut, 1);

    // R7 selective clears
    clearFlags(2'b01);
    check("R7 full only", fullOut, 0);
    check("R7 ovr kept", overrunOut, 1);
    clearFlags(2'b00);
    check("R7 zero write", overrunOut, 1);
    clearFlags(2'b10);
    check("R7 ovr cleared", overrunOut, 0);

    // R8 boundary ignored in ESF
    pulseMf();
    settle();
    check("R8 data", dataOut, 8'hC3);
    check("R8 full", fullOut, 0);

    // R9 mode change drops partial byte
    maskFull = 1'b1;
    sendBits(8'h07, 3);
    modeD4 = 1'b1;
    settle();
    modeD4 = 1'b0;
    settle();
    sendBits(8'h96, 5);
    settle();
    check("R9 no early byte", fullOut, 0);
    sendBits(8'h96 >> 5, 3);
    settle();
    check("R9 restarted byte", dataOut, 8'h96);
    check("R9 full", fullOut, 1);

    // R7 clear coincides with transfer: set wins, no overrun
    sendBits(8'h3C, 8);
    clrWrEn = 1'b1;
    clrBits = 2'b01;
    @(negedge clk);
    clrWrEn = 1'b0;
    clrBits = 2'b00;
    settle();
    check("R7 set wins", fullOut, 1);
    check("R7 no overrun", overrunOut, 0);
    check("R7 data", dataOut, 8'h3C);

    // R4 last Fs bit together with boundary
    clearFlags(2'b11);
    modeD4 = 1'b1;
    settle();
    sendBits(8'h15, 5);
    @(negedge clk);
    slotBit = 1'b1; slotStrobe = 1'b1; mfStrobe = 1'b1;
    @(negedge clk);
    slotStrobe = 1'b0; mfStrobe = 1'b0;
    settle();
    check("R4 same-cycle boundary", dataOut, 8'h35);

    finishRun();
  end

endmodule